// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps a running calendar clock: seconds, minutes, hours, weekday, day of the month, month and a two-digit year. The century is fixed by a parameter. Each one-cycle `tick` pulse advances the clock by one second. All carries are resolved in one edge, including those across month ends and leap days. The count is held internally in binary.

The block also keeps a byte-wide register image of the seven fields. It refreshes that image from the count on every tick. Two format inputs select how the image is written: BCD or binary, and 12-hour or 24-hour. Software-style writes arrive on a byte load port in the same register format and are decoded back into the count.

A `hold` input freezes the image so that it can be read or rewritten as a consistent set while the internal count keeps running. Bytes written during the hold are applied to the count at the edge where `hold` is released.

Top module: `caltime_core`

## Requirements
- R1: After reset the image reads seconds 0, minutes 0, hours 0, weekday FIRST_WDAY (6 by default), day 1, month 1 and year 0, regardless of the format inputs.
- R2: With `fmt_bin`=0 each image byte is BCD, with tens in bits 7:4 and units in bits 3:0. With `fmt_bin`=1 it is plain binary. A format change takes effect at the next tick refresh and leaves the image unchanged until then.
- R3: With `fmt_24h`=1 the hours byte holds 0..23. With `fmt_24h`=0 it holds the hour modulo 12 in bits 6:0, and bit 7 is set when the hour is 12 or more.
- R4: A loaded hours byte is decoded from bits 6:0. In 12-hour mode, 12 is added when bit 7 is set.
- R5: Seconds and minutes wrap from 59 to 0 and carry upward. Hours wrap from 23 to 0 and advance both the weekday and the day of the month. The weekday counts 0..6 and wraps to 0.
- R6: Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31. February has 29 days when the full year (BASE_YEAR plus the two-digit year) is divisible by 4 and either not by 100 or by 400. The month runs 1..12. The year runs 0..99 and wraps to 0 after 99.
- R7: While `hold`=1 the image does not change on ticks and the count keeps running. A byte written during the hold appears in the image at once. If bytes were written during the hold, the count is reloaded from the whole image at the edge where `hold` falls. Otherwise the count simply continues.
- R8: With `ld_en`=1 and `hold`=0, the byte `ld_data` is written into the field chosen by `ld_sel` (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year). The count is reloaded from the image in that same edge, and a tick in that cycle is dropped. A `ld_sel` of 7 changes nothing.
- R9: A day of the month loaded as 0 or above the month length becomes 1 at the next day rollover, and the month advances in the above-length case. A month above 12 becomes 1 at that rollover, with a year carry.
- R10: Every field that changes on a tick changes in the same edge, so the image never shows a partly carried time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse: advance one second |
| fmt_bin | input | 1 | 1 = binary image, 0 = BCD image |
| fmt_24h | input | 1 | 1 = 24-hour hours byte, 0 = 12-hour with PM in bit 7 |
| hold | input | 1 | Freeze the image and defer loads to the count |
| ld_en | input | 1 | Write `ld_data` into the image field chosen by `ld_sel` |
| ld_sel | input | 3 | Field select: 0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year |
| ld_data | input | 8 | Byte to load, in the current image format |
| sec_o | output | 8 | Seconds byte of the image |
| min_o | output | 8 | Minutes byte of the image |
| hour_o | output | 8 | Hours byte of the image |
| wday_o | output | 8 | Weekday byte of the image |
| mday_o | output | 8 | Day-of-month byte of the image |
| mon_o | output | 8 | Month byte of the image |
| year_o | output | 8 | Two-digit year byte of the image |

## Verification
Each result is due exactly one rising edge after its stimulus. A tick, a load and a hold release each change the image in the edge that samples them, and a format change changes nothing until the following tick. The bench drives every input on the falling edge, lets one rising edge pass, and compares all seven bytes together on the next falling edge, so no comparison ever sees a half-carried time. Expected bytes come from an arithmetic model of the calendar and of both encodings in the bench. The hold cases compare against a snapshot taken before the hold.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

   localparam int NF     = 7;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_WDAY = 3;
   localparam int F_MDAY = 4;
   localparam int F_MON  = 5;
   localparam int F_YEAR = 6;

   typedef logic [NF-1:0][7:0] cal_vec_t;

   // binary value (0..99) to register byte
   function automatic logic [7:0] enc_val(input logic [7:0] v, input logic bin);
      logic [7:0] t;
      logic [7:0] u;
      t = v / 8'd10;
      u = v % 8'd10;
      if (bin) return v;
      return {t[3:0], u[3:0]};
   endfunction

   // register byte to binary value
   function automatic logic [7:0] dec_val(input logic [7:0] b, input logic bin);
      if (bin) return b;
      return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
   endfunction

   function automatic logic [7:0] enc_hour(input logic [7:0] h, input logic bin,
                                           input logic h24);
      logic [7:0] e;
      if (h24) return enc_val(h, bin);
      e = enc_val(h % 8'd12, bin);
      return e | {(h >= 8'd12), 7'd0};
   endfunction

   function automatic logic [7:0] dec_hour(input logic [7:0] b, input logic bin,
                                           input logic h24);
      logic [7:0] v;
      v = dec_val({1'b0, b[6:0]}, bin);
      if (!h24 && b[7]) v = v + 8'd12;
      return v;
   endfunction

   function automatic logic is_leap(input logic [7:0] yr, input int base);
      int fy;
      fy = base + {24'd0, yr};
      return ((fy % 4) == 0) && (((fy % 100) != 0) || ((fy % 400) == 0));
   endfunction

   function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
      case (mon)
         8'd2:                       return leap ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11:    return 8'd30;
         default:                    return 8'd31;
      endcase
   endfunction

endpackage

// File: rtl/caltime_step.sv
module caltime_step
   import caltime_pkg::*;
#(
   parameter int BASE_YEAR = 2000
) (
   input  cal_vec_t cur,
   output cal_vec_t nxt
);

   logic [7:0] s1, m1, h1, w1, d1, mo1, dim;
   logic       c_sec, c_min, c_hour, c_mday;

   always_comb begin
      nxt    = cur;
      c_min  = 1'b0;
      c_hour = 1'b0;
      c_mday = 1'b0;
      m1     = cur[F_MIN] + 8'd1;
      h1     = cur[F_HOUR] + 8'd1;
      w1     = cur[F_WDAY] + 8'd1;
      d1     = cur[F_MDAY] + 8'd1;
      mo1    = cur[F_MON] + 8'd1;
      dim    = month_days(cur[F_MON], is_leap(cur[F_YEAR], BASE_YEAR));

      s1     = cur[F_SEC] + 8'd1;
      c_sec  = (s1 >= 8'd60);
      nxt[F_SEC] = c_sec ? 8'd0 : s1;

      if (c_sec) begin
         c_min      = (m1 >= 8'd60);
         nxt[F_MIN] = c_min ? 8'd0 : m1;
      end
      if (c_min) begin
         c_hour      = (h1 >= 8'd24);
         nxt[F_HOUR] = c_hour ? 8'd0 : h1;
      end
      if (c_hour) begin
         nxt[F_WDAY] = (w1 >= 8'd7) ? 8'd0 : w1;
         c_mday      = (d1 > dim);
         nxt[F_MDAY] = c_mday ? 8'd1 : d1;
      end
      if (c_mday) begin
         if (mo1 > 8'd12) begin
            nxt[F_MON]  = 8'd1;
            nxt[F_YEAR] = (cur[F_YEAR] >= 8'd99) ? 8'd0 : cur[F_YEAR] + 8'd1;
         end else begin
            nxt[F_MON]  = mo1;
         end
      end
   end

endmodule

// File: rtl/caltime_pack.sv
module caltime_pack
   import caltime_pkg::*;
(
   input  cal_vec_t val,
   input  logic     fmt_bin,
   input  logic     fmt_24h,
   output cal_vec_t img
);

   for (genvar f = 0; f < NF; f++) begin : g_fld
      if (f == F_HOUR) begin : g_hr
         assign img[f] = enc_hour(val[f], fmt_bin, fmt_24h);
      end else begin : g_plain
         assign img[f] = enc_val(val[f], fmt_bin);
      end
   end

endmodule

// File: rtl/caltime_unpack.sv
module caltime_unpack
   import caltime_pkg::*;
(
   input  cal_vec_t img,
   input  logic     fmt_bin,
   input  logic     fmt_24h,
   output cal_vec_t val
);

   for (genvar f = 0; f < NF; f++) begin : g_fld
      if (f == F_HOUR) begin : g_hr
         assign val[f] = dec_hour(img[f], fmt_bin, fmt_24h);
      end else begin : g_plain
         assign val[f] = dec_val(img[f], fmt_bin);
      end
   end

endmodule

// File: rtl/caltime_core.sv
module caltime_core
   import caltime_pkg::*;
#(
   parameter int BASE_YEAR  = 2000,
   parameter int FIRST_WDAY = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       fmt_bin,
   input  logic       fmt_24h,
   input  logic       hold,
   input  logic       ld_en,
   input  logic [2:0] ld_sel,
   input  logic [7:0] ld_data,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] wday_o,
   output logic [7:0] mday_o,
   output logic [7:0] mon_o,
   output logic [7:0] year_o
);

   if ((BASE_YEAR % 100) != 0 || BASE_YEAR < 0) begin : g_bad_base
      $error("BASE_YEAR must be a non-negative multiple of 100");
   end
   if (FIRST_WDAY < 0 || FIRST_WDAY > 6) begin : g_bad_wday
      $error("FIRST_WDAY must lie in 0..6");
   end

   localparam cal_vec_t RST_VEC = {8'd0, 8'd1, 8'd1, 8'(FIRST_WDAY), 8'd0, 8'd0, 8'd0};

   cal_vec_t cnt_q, img_q, merged, dec_v, nxt_v, enc_v;
   logic     hold_q, dirty_q, ld_hit, commit;

   assign ld_hit = ld_en && (ld_sel < 3'(NF));
   assign commit = (ld_hit && !hold) || (hold_q && !hold && dirty_q);

   always_comb begin
      merged = img_q;
      if (ld_hit) merged[ld_sel] = ld_data;
   end

   caltime_unpack u_unpack (.img(merged), .fmt_bin(fmt_bin), .fmt_24h(fmt_24h), .val(dec_v));
   caltime_step #(.BASE_YEAR(BASE_YEAR)) u_step (.cur(cnt_q), .nxt(nxt_v));
   caltime_pack u_pack (.val(nxt_v), .fmt_bin(fmt_bin), .fmt_24h(fmt_24h), .img(enc_v));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= RST_VEC;
         img_q   <= RST_VEC;
         hold_q  <= 1'b0;
         dirty_q <= 1'b0;
      end else begin
         hold_q  <= hold;
         dirty_q <= hold ? (dirty_q | ld_hit) : 1'b0;
         if (commit) begin
            cnt_q <= dec_v;
            img_q <= merged;
         end else if (tick) begin
            cnt_q <= nxt_v;
            img_q <= hold ? merged : enc_v;
         end else begin
            img_q <= merged;
         end
      end
   end

   assign sec_o  = img_q[F_SEC];
   assign min_o  = img_q[F_MIN];
   assign hour_o = img_q[F_HOUR];
   assign wday_o = img_q[F_WDAY];
   assign mday_o = img_q[F_MDAY];
   assign mon_o  = img_q[F_MON];
   assign year_o = img_q[F_YEAR];

   // R5
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !commit) |=> (cnt_q[F_SEC] < 8'd60));

   // R5
   min_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !commit && cnt_q[F_SEC] < 8'd59) |=> $stable(cnt_q[F_MIN]));

   // R5
   wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !commit && cnt_q[F_SEC] == 8'd59 && cnt_q[F_MIN] == 8'd59 &&
       cnt_q[F_HOUR] == 8'd23 && cnt_q[F_WDAY] == 8'd6) |=> (cnt_q[F_WDAY] == 8'd0));

   // R7
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !ld_hit) |=> $stable(img_q));

   // R8
   load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !hold && ld_sel == 3'd0) |=> (sec_o == $past(ld_data)));

endmodule

// File: tb/caltime_core_bench.sv
module caltime_core_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, fmt_bin = 1'b0, fmt_24h = 1'b0, hold = 1'b0, ld_en = 1'b0;
   logic [2:0] ld_sel = 3'd0;
   logic [7:0] ld_data = 8'd0;
   logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

   int checks = 0, errors = 0;
   int ms, mm, mh, mw, md, mo, my;

   always #2 clk = ~clk;

   caltime_core u_caltime_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fmt_bin(fmt_bin), .fmt_24h(fmt_24h),
      .hold(hold), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
      .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o));

   function automatic logic [7:0] e(int v);
      if (fmt_bin) return 8'(v);
      return 8'(((v / 10) * 16) + (v % 10));
   endfunction

   function automatic logic [7:0] eh(int h);
      if (fmt_24h) return e(h);
      return e(h % 12) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   function automatic int bdim(int m, int y);
      int fy;
      bit lp;
      fy = 2000 + y;
      lp = ((fy % 4) == 0) && (((fy % 100) != 0) || ((fy % 400) == 0));
      case (m)
         2:           return lp ? 29 : 28;
         4, 6, 9, 11: return 30;
         default:     return 31;
      endcase
   endfunction

   function automatic logic [55:0] expv();
      return {e(my), e(mo), e(md), e(mw), eh(mh), e(mm), e(ms)};
   endfunction

   function automatic logic [55:0] actv();
      return {year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o};
   endfunction

   task automatic madv();
      ms++;
      if (ms >= 60) begin
         ms = 0; mm++;
         if (mm >= 60) begin
            mm = 0; mh++;
            if (mh >= 24) begin
               mh = 0;
               mw = (mw + 1 >= 7) ? 0 : mw + 1;
               md++;
               if (md > bdim(mo, my)) begin
                  md = 1; mo++;
                  if (mo > 12) begin
                     mo = 1;
                     my = (my >= 99) ? 0 : my + 1;
                  end
               end
            end
         end
      end
   endtask

   task automatic chk(string req, logic [55:0] act, logic [55:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tk();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic wr(int sel, logic [7:0] d);
      ld_en = 1'b1; ld_sel = 3'(sel); ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic load_all(int s, int m, int h, int w, int d, int mon, int y);
      ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y;
      hold = 1'b1;
      @(negedge clk);
      wr(0, e(s)); wr(1, e(m)); wr(2, eh(h)); wr(3, e(w));
      wr(4, e(d)); wr(5, e(mon)); wr(6, e(y));
      hold = 1'b0;
      @(negedge clk);
      chk("R7 image after release of a hold with writes", actv(), expv());
   endtask

   initial begin
      #(4 * 150000);
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [55:0] snap;
      int yrs[4];
      yrs = '{23, 24, 0, 99};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset image
      chk("R1 reset image", actv(), {8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00});

      // R2 R3 R4: every hour in every format, rolling to a leap day
      for (int m = 0; m < 4; m++) begin
         fmt_bin = m[0]; fmt_24h = m[1];
         for (int h = 0; h < 24; h++) begin
            load_all(59, 59, h, 3, 28, 2, 24);
            tk(); madv();
            chk("R2 R3 R4 hour format after tick", actv(), expv());
         end
      end

      // R6 R10: last day of each month in several years
      fmt_bin = 1'b0; fmt_24h = 1'b1;
      for (int yi = 0; yi < 4; yi++) begin
         for (int mon = 1; mon <= 12; mon++) begin
            load_all(59, 59, 23, 6, bdim(mon, yrs[yi]), mon, yrs[yi]);
            tk(); madv();
            chk("R6 R10 month end rollover", actv(), expv());
         end
      end

      // R5: long run across the year end, binary 12-hour
      fmt_bin = 1'b1; fmt_24h = 1'b0;
      load_all(0, 58, 23, 5, 31, 12, 0);
      for (int i = 0; i < 200; i++) begin
         tk(); madv();
         chk("R5 carry chain", actv(), expv());
      end

      // R7: hold without writes keeps counting
      fmt_bin = 1'b0; fmt_24h = 1'b1;
      load_all(30, 20, 10, 2, 15, 6, 10);
      snap = expv();
      hold = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin tk(); madv(); end
      chk("R7 image frozen under hold", actv(), snap);
      hold = 1'b0;
      @(negedge clk);
      chk("R7 release without writes keeps image", actv(), snap);
      tk(); madv();
      chk("R7 count ran during hold", actv(), expv());

      // R7: write during hold is deferred to release
      hold = 1'b1;
      @(negedge clk);
      wr(0, e(45)); ms = 45;
      chk("R7 written byte visible during hold", actv(), expv());
      tk(); tk();
      chk("R7 image frozen after write", actv(), expv());
      hold = 1'b0;
      @(negedge clk);
      chk("R7 release commits image", actv(), expv());
      tk(); madv();
      chk("R7 count restarts from written time", actv(), expv());

      // R8: load with hold low wins over a same-cycle tick
      tick = 1'b1;
      wr(1, e(7)); tick = 1'b0; mm = 7;
      chk("R8 load drops same-cycle tick", actv(), expv());
      tk(); madv();
      chk("R8 count follows load", actv(), expv());
      wr(7, 8'h55);
      chk("R8 select 7 ignored", actv(), expv());

      // R9: out-of-range day and month
      load_all(59, 59, 23, 1, 0, 3, 5);
      tk(); madv();
      chk("R9 day 0 becomes 1", actv(), expv());
      load_all(59, 59, 23, 1, 45, 4, 5);
      tk(); madv();
      chk("R9 day 45 becomes 1 next month", actv(), expv());
      load_all(59, 59, 23, 1, 31, 13, 99);
      tk(); madv();
      chk("R9 month 13 wraps with year carry", actv(), expv());

      // R2: format change waits for the next tick
      load_all(12, 34, 15, 4, 19, 8, 47);
      snap = expv();
      fmt_bin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R2 image unchanged until tick", actv(), snap);
      tk(); madv();
      chk("R2 binary after tick", actv(), expv());

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule